// File: doc/BRIEF.md
# Keyed Configuration Index/Data Port

This block is a two-address configuration port that gives access to a small bank of 8-bit configuration registers. One bus address carries an index (a register pointer), the address one above it carries the data of whatever register the index points at. Nothing behind the port can be read or changed until software writes an enter key byte to the index address on two consecutive index writes. A leave key written to the index address shuts the port again. The point of the keying is that stray bus traffic cannot reprogram the configuration by accident.

While open, the port holds a logical-device number that selects which device's registers the data address reaches. It serves a read-only chip identification byte and a per-device activate bit itself. It passes every higher index on to the attached function blocks as single-cycle read and write strobes, tagged with the selected device and index. Those blocks answer reads combinationally on `fn_rdata`.

The key state machine has three states:
- `ST_LOCKED`: the port is shut.
- `ST_KEY_HALF`: one enter key has been seen.
- `ST_OPEN`: the port is unlocked.

Its transitions are:
- From `ST_LOCKED`, an enter-key index write moves it to `ST_KEY_HALF` (arm).
- From `ST_KEY_HALF`, a second enter-key index write moves it to `ST_OPEN` (unlock).
- From `ST_KEY_HALF`, any other index write moves it back to `ST_LOCKED` (restart).
- From `ST_OPEN`, a leave-key index write moves it to `ST_LOCKED` (leave).
- From `ST_OPEN`, any other index write loads the index register and the state stays `ST_OPEN` (point).

Top module: `cfgport_keyed`

## Requirements
- R1: After reset the port is locked. The logical-device select reads 0 once the port is opened, and `dev_active` is all zeros.
- R2: The index register answers only at `BASE_ADDR` and the data register only at `BASE_ADDR`+1. Accesses to any other address have no effect on the key sequence or the registers. Reads of any other address return 0x00.
- R3: Two consecutive index-address writes of the enter key open the port. The enter key is 0x87, or 0x88 when `ALT_KEYS`=1.
- R4: In `ST_KEY_HALF`, an index-address write of any value other than the enter key returns the port to `ST_LOCKED`, so the full two-write sequence must start again. Data-address accesses between the two key writes do not break the sequence.
- R5: While open, writing the leave key to the index address locks the port. The leave key is 0xAA, or 0xBB when `ALT_KEYS`=1. Any other index write loads the index register. A read of the index address returns the current index.
- R6: While locked, reads of both port addresses return 0xFF, data-address writes change no register, and no function strobe fires.
- R7: Index 0x07 is the logical-device select register. It is fully readable and writable.
- R8: Index 0x20 returns `CHIP_ID`. Writes to index 0x20 are ignored.
- R9: At index 0x30, bit 0 is the activate bit of the selected device, and the other bits read 0. `dev_active[n]` reflects the activate bit of device n. For a selected device number of `NUM_LDEV` or above, index 0x30 reads 0x00 and writes are dropped.
- R10: While open, a data-address access with index 0x31 or above raises `fn_wr` or `fn_rd` in the same cycle as the bus strobe. During such an access, `fn_index`, `fn_ldev` and `fn_wdata` carry the index, the device and the byte, and a read returns `fn_rdata`. Indices below 0x30 other than 0x07 and 0x20 read 0x00, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 8 | Bus write byte |
| bus_rdata | output | 8 | Bus read byte, valid in the cycle of `bus_rd` |
| fn_wr | output | 1 | Write strobe to the function blocks |
| fn_rd | output | 1 | Read strobe to the function blocks |
| fn_index | output | 8 | Current register index |
| fn_ldev | output | 8 | Selected logical device |
| fn_wdata | output | 8 | Byte for a function write |
| fn_rdata | input | 8 | Byte returned by the function blocks |
| dev_active | output | NUM_LDEV | Activate bit of each logical device |

## Verification
The hardest condition to reach from the ports is the half-keyed state followed by each possible interrupting byte: only one of 256 values may complete the unlock. The bench sweeps every byte value as the second index write between two enter keys, then probes the index address. This shows whether the port opened, stayed half-keyed or restarted. A separate sequence puts data-address traffic between the keys, and another writes data while locked, then unlocks and reads the untouched register back.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [1:0] {
        ST_LOCKED   = 2'd0,
        ST_KEY_HALF = 2'd1,
        ST_OPEN     = 2'd2
    } key_state_e;

    localparam logic [7:0] IDX_LDEV_SEL = 8'h07;
    localparam logic [7:0] IDX_CHIP_ID  = 8'h20;
    localparam logic [7:0] IDX_ACTIVATE = 8'h30;
    localparam logic [7:0] IDX_FN_FIRST = 8'h31;
    localparam logic [7:0] LOCKED_READ  = 8'hFF;

    function automatic logic [7:0] enter_key(input logic alt);
        return alt ? 8'h88 : 8'h87;
    endfunction

    function automatic logic [7:0] leave_key(input logic alt);
        return alt ? 8'hBB : 8'hAA;
    endfunction

endpackage

// File: rtl/cfgport_keyfsm.sv
module cfgport_keyfsm
    import cfgport_pkg::*;
#(
    parameter bit ALT_KEYS = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       cfg_open,
    output logic       idx_load
);
    localparam logic [7:0] KEY_IN  = enter_key(ALT_KEYS);
    localparam logic [7:0] KEY_OUT = leave_key(ALT_KEYS);

    key_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOCKED;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOCKED:   if (idx_wr && wdata == KEY_IN) state_nx = ST_KEY_HALF;
            ST_KEY_HALF: if (idx_wr) state_nx = (wdata == KEY_IN) ? ST_OPEN : ST_LOCKED;
            ST_OPEN:     if (idx_wr && wdata == KEY_OUT) state_nx = ST_LOCKED;
            default:     state_nx = ST_LOCKED;
        endcase
    end

    always_comb begin
        cfg_open = (state == ST_OPEN);
        idx_load = cfg_open && idx_wr && (wdata != KEY_OUT);
    end

endmodule

// File: rtl/cfgport_regbank.sv
module cfgport_regbank
    import cfgport_pkg::*;
#(
    parameter int NUM_LDEV = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                idx_load,
    input  logic                dat_wr,
    input  logic [7:0]          wdata,
    output logic [7:0]          cur_index,
    output logic [7:0]          cur_ldev,
    output logic [NUM_LDEV-1:0] dev_active
);
    always_ff @(posedge clk) begin
        if (!rst_n)        cur_index <= 8'h00;
        else if (idx_load) cur_index <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                     cur_ldev <= 8'h00;
        else if (dat_wr && cur_index == IDX_LDEV_SEL)   cur_ldev <= wdata;
    end

    for (genvar g = 0; g < NUM_LDEV; g++) begin : g_act
        localparam logic [7:0] DEV_NUM = 8'(g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                dev_active[g] <= 1'b0;
            else if (dat_wr && cur_index == IDX_ACTIVATE && cur_ldev == DEV_NUM)
                dev_active[g] <= wdata[0];
        end
    end

endmodule

// File: rtl/cfgport_access.sv
module cfgport_access
    import cfgport_pkg::*;
#(
    parameter int         NUM_LDEV = 16,
    parameter logic [7:0] CHIP_ID  = 8'h52
) (
    input  logic                cfg_open,
    input  logic                bus_rd,
    input  logic                bus_wr,
    input  logic                hit_idx,
    input  logic                hit_dat,
    input  logic [7:0]          cur_index,
    input  logic [7:0]          cur_ldev,
    input  logic [NUM_LDEV-1:0] dev_active,
    input  logic [7:0]          fn_rdata,
    output logic [7:0]          bus_rdata,
    output logic                fn_wr,
    output logic                fn_rd
);
    localparam int         LDEV_W   = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;
    localparam logic [7:0] LDEV_LIM = 8'(NUM_LDEV);

    logic       fn_range;
    logic [7:0] act_byte;
    logic [7:0] reg_byte;

    always_comb begin
        fn_range = (cur_index >= IDX_FN_FIRST);
        fn_wr    = cfg_open && hit_dat && bus_wr && fn_range;
        fn_rd    = cfg_open && hit_dat && bus_rd && fn_range;
        act_byte = 8'h00;
        if (cur_ldev < LDEV_LIM)
            act_byte[0] = dev_active[cur_ldev[LDEV_W-1:0]];
        if (fn_range)                        reg_byte = fn_rdata;
        else if (cur_index == IDX_LDEV_SEL)  reg_byte = cur_ldev;
        else if (cur_index == IDX_CHIP_ID)   reg_byte = CHIP_ID;
        else if (cur_index == IDX_ACTIVATE)  reg_byte = act_byte;
        else                                 reg_byte = 8'h00;
        if (!(hit_idx || hit_dat))  bus_rdata = 8'h00;
        else if (!cfg_open)         bus_rdata = LOCKED_READ;
        else if (hit_idx)           bus_rdata = cur_index;
        else                        bus_rdata = reg_byte;
    end

endmodule

// File: rtl/cfgport_keyed.sv
module cfgport_keyed
    import cfgport_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h002E,
    parameter bit                ALT_KEYS  = 1'b0,
    parameter logic [7:0]        CHIP_ID   = 8'h52,
    parameter int                NUM_LDEV  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [7:0]          bus_wdata,
    output logic [7:0]          bus_rdata,
    output logic                fn_wr,
    output logic                fn_rd,
    output logic [7:0]          fn_index,
    output logic [7:0]          fn_ldev,
    output logic [7:0]          fn_wdata,
    input  logic [7:0]          fn_rdata,
    output logic [NUM_LDEV-1:0] dev_active
);
    localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + 1'b1;

    logic       hit_idx, hit_dat, idx_wr, dat_wr;
    logic       cfg_open, idx_load;
    logic [7:0] cur_index, cur_ldev;

    assign hit_idx = (bus_addr == BASE_ADDR);
    assign hit_dat = (bus_addr == DATA_ADDR);
    assign idx_wr  = bus_wr && hit_idx;
    assign dat_wr  = bus_wr && hit_dat && cfg_open;

    cfgport_keyfsm #(.ALT_KEYS(ALT_KEYS)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_wr   (idx_wr),
        .wdata    (bus_wdata),
        .cfg_open (cfg_open),
        .idx_load (idx_load)
    );

    cfgport_regbank #(.NUM_LDEV(NUM_LDEV)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx_load   (idx_load),
        .dat_wr     (dat_wr),
        .wdata      (bus_wdata),
        .cur_index  (cur_index),
        .cur_ldev   (cur_ldev),
        .dev_active (dev_active)
    );

    cfgport_access #(.NUM_LDEV(NUM_LDEV), .CHIP_ID(CHIP_ID)) u_acc (
        .cfg_open   (cfg_open),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .hit_idx    (hit_idx),
        .hit_dat    (hit_dat),
        .cur_index  (cur_index),
        .cur_ldev   (cur_ldev),
        .dev_active (dev_active),
        .fn_rdata   (fn_rdata),
        .bus_rdata  (bus_rdata),
        .fn_wr      (fn_wr),
        .fn_rd      (fn_rd)
    );

    assign fn_index = cur_index;
    assign fn_ldev  = cur_ldev;
    assign fn_wdata = bus_wdata;

endmodule

// File: rtl/cfgport_keyed_chk.sv
module cfgport_keyed_chk
    import cfgport_pkg::*;
#(
    parameter bit         ALT_KEYS = 1'b0,
    parameter logic [7:0] CHIP_ID  = 8'h52,
    parameter int         NUM_LDEV = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_open,
    input logic                idx_wr,
    input logic                hit_idx,
    input logic                hit_dat,
    input logic                bus_rd,
    input logic [7:0]          bus_wdata,
    input logic [7:0]          bus_rdata,
    input logic [7:0]          cur_index,
    input logic                fn_wr,
    input logic                fn_rd,
    input logic [NUM_LDEV-1:0] dev_active
);
    localparam logic [7:0] KEY_IN  = enter_key(ALT_KEYS);
    localparam logic [7:0] KEY_OUT = leave_key(ALT_KEYS);

    a_r3_open_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(idx_wr && bus_wdata == KEY_IN));

    a_r5_leave_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && idx_wr && bus_wdata == KEY_OUT) |=> !cfg_open);

    a_r6_locked_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_open && bus_rd && (hit_idx || hit_dat)) |-> bus_rdata == 8'hFF);

    a_r6_locked_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |-> !(fn_wr || fn_rd));

    a_r9_active_frozen_locked: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> $stable(dev_active));

    a_r8_chip_id: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_open && bus_rd && hit_dat && cur_index == IDX_CHIP_ID) |-> bus_rdata == CHIP_ID);

endmodule

bind cfgport_keyed cfgport_keyed_chk #(
    .ALT_KEYS (ALT_KEYS),
    .CHIP_ID  (CHIP_ID),
    .NUM_LDEV (NUM_LDEV)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_open   (cfg_open),
    .idx_wr     (idx_wr),
    .hit_idx    (hit_idx),
    .hit_dat    (hit_dat),
    .bus_rd     (bus_rd),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cur_index  (cur_index),
    .fn_wr      (fn_wr),
    .fn_rd      (fn_rd),
    .dev_active (dev_active)
);

// File: tb/cfgport_keyed_bench.sv
module cfgport_keyed_bench;
    localparam int          NL    = 16;
    localparam logic [15:0] IA    = 16'h002E;
    localparam logic [15:0] DA    = 16'h002F;
    localparam logic [7:0]  ENT   = 8'h87;
    localparam logic [7:0]  LVE   = 8'hAA;
    localparam logic [7:0]  CID   = 8'h52;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   bus_addr = '0;
    logic          bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;
    logic          fn_wr, fn_rd;
    logic [7:0]    fn_index, fn_ldev, fn_wdata, fn_rdata;
    logic [NL-1:0] dev_active;

    int nvec = 0, nbad = 0;
    logic       c_fnwr, c_fnrd;
    logic [7:0] c_idx, c_ldev, c_wd, c_rd;

    always #2.5 clk = ~clk;

    assign fn_rdata = fn_index + 8'(fn_ldev * 3);

    cfgport_keyed u_cfgport_keyed (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fn_wr(fn_wr), .fn_rd(fn_rd), .fn_index(fn_index), .fn_ldev(fn_ldev),
        .fn_wdata(fn_wdata), .fn_rdata(fn_rdata), .dev_active(dev_active)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        nvec++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        c_fnwr = fn_wr; c_idx = fn_index; c_ldev = fn_ldev; c_wd = fn_wdata;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        c_rd = bus_rdata; c_fnrd = fn_rd;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic unlock();
        wr(IA, ENT); wr(IA, ENT);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [NL-1:0] exp_act;
        logic [7:0]    e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 dev_active", 32'(dev_active), 0);
        rd(IA); chk("R1 locked index read", 32'(c_rd), 32'hFF);
        rd(DA); chk("R6 locked data read", 32'(c_rd), 32'hFF);
        unlock(); wr(IA, 8'h07); rd(DA); chk("R1 ldev after reset", 32'(c_rd), 0);
        // R6 locked data write ignored
        wr(IA, 8'h30); wr(IA, LVE);
        wr(DA, 8'h01); chk("R6 no strobe locked", 32'(c_fnwr), 0);
        unlock(); rd(DA); chk("R6 locked write dropped", 32'(c_rd), 0);
        chk("R6 dev_active", 32'(dev_active), 0);
        wr(IA, LVE);
        // R3/R4 sweep of interrupting byte
        for (int v = 0; v < 256; v++) begin
            wr(IA, ENT); wr(IA, 8'(v)); wr(IA, ENT);
            rd(IA);
            if (8'(v) == ENT) chk("R3 unlock via enter", 32'(c_rd), 32'(ENT));
            else              chk("R4 restart on other byte", 32'(c_rd), 32'hFF);
            wr(IA, LVE);
        end
        // R4 data traffic between keys does not break sequence
        wr(IA, ENT); wr(DA, 8'h33); rd(DA); wr(IA, ENT);
        rd(IA); chk("R4 data between keys", 32'(c_rd), 32'(ENT));
        wr(IA, LVE);
        // R2 other addresses ignored
        wr(16'h004E, ENT); wr(16'h004E, ENT);
        rd(IA); chk("R2 foreign address no unlock", 32'(c_rd), 32'hFF);
        rd(16'h004F); chk("R2 foreign read zero", 32'(c_rd), 0);
        // R7..R10 read sweep over all indices, device 3
        unlock(); wr(IA, 8'h07); wr(DA, 8'h03);
        for (int v = 0; v < 256; v++) begin
            if (8'(v) == LVE) continue;
            wr(IA, 8'(v));
            rd(IA); chk("R5 index readback", 32'(c_rd), 32'(v));
            rd(DA);
            if (v >= 8'h31) begin
                e = 8'(v) + 8'd9;
                chk("R10 fn read data", 32'(c_rd), 32'(e));
                chk("R10 fn_rd strobe", 32'(c_fnrd), 1);
            end else begin
                if (v == 8'h07)      e = 8'h03;
                else if (v == 8'h20) e = CID;
                else                 e = 8'h00;
                chk("R7 R8 R9 R10 local read", 32'(c_rd), 32'(e));
                chk("R10 no fn_rd", 32'(c_fnrd), 0);
            end
        end
        // R9 activate sweep across devices incl. out of range
        exp_act = '0;
        for (int d = 0; d < NL + 2; d++) begin
            wr(IA, 8'h07); wr(DA, 8'(d));
            wr(IA, 8'h30); wr(DA, 8'hFE | 8'(d % 2));
            if (d < NL) exp_act[d] = 1'(d % 2);
            rd(DA); chk("R9 activate readback", 32'(c_rd), (d < NL) ? 32'(d % 2) : 0);
        end
        chk("R9 dev_active map", 32'(dev_active), 32'(exp_act));
        // R8 chip id write ignored
        wr(IA, 8'h20); wr(DA, 8'h00); rd(DA); chk("R8 chip id ro", 32'(c_rd), 32'(CID));
        // R10 forward write
        wr(IA, 8'h07); wr(DA, 8'h05);
        wr(IA, 8'h45); wr(DA, 8'h5A);
        chk("R10 fn_wr", 32'(c_fnwr), 1);
        chk("R10 fn_index", 32'(c_idx), 32'h45);
        chk("R10 fn_ldev", 32'(c_ldev), 5);
        chk("R10 fn_wdata", 32'(c_wd), 32'h5A);
        wr(IA, 8'h10); wr(DA, 8'h77); chk("R10 low index no fn_wr", 32'(c_fnwr), 0);
        rd(DA); chk("R10 low index reads 0", 32'(c_rd), 0);
        // R5 leave
        wr(IA, LVE); rd(IA); chk("R5 leave locks", 32'(c_rd), 32'hFF);
        rd(DA); chk("R6 locked after leave", 32'(c_rd), 32'hFF);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule